// File: doc/BRIEF.md
# Processor Reset and Boot Sequencer

This block controls reset and start-up for a small processor core. The `pwr_ok` input is an asynchronous active-low reset: while it is low, power is not yet valid and the whole block sits in its initial state. After `pwr_ok` rises, the core is held in reset for a fixed settling window of reference-clock cycles, so that an upstream clock multiplier can lock. Once the window has elapsed and the external reset pin is released, the core is let go.

Later resets arrive on the external active-low reset pin. They need no settling window, because the clocks keep running. The pin is first synchronized by two flops. A low level is then taken as a reset only if it lasts at least a configurable number of consecutive cycles, and shorter dips are ignored. While the core is in reset, the block asserts three side-effect strobes: clear the stack pointers, mask every interrupt and clear the mode/status register.

On release, a pending bus request parks the block in a hold state until the request drops. If the boot strap is set, the block then runs a start/done boot handshake. Whether or not a boot ran, the block finally issues a single fetch request to program address zero.

Top module: `rst_boot_seq`

## Requirements
- R1: After `pwr_ok` rises, `phase` reads POR_WAIT (code 0) for exactly LOCK_CYCLES clock edges. Only after that does it leave code 0.
- R2: If the synchronized external reset is still low when the settling window ends, `phase` stays at RESET_HELD (code 1) and no fetch is issued until the pin goes high. Once `phase` has left code 0, it never returns to code 0 until `pwr_ok` falls.
- R3: A later reset takes effect only when `rst_ext_n` is low for at least MIN_PULSE consecutive clock edges. With a shorter low pulse, `core_hold` stays low and no new fetch is issued.
- R4: `sp_clear`, `irq_mask_all` and `mstat_clr` are all high while `phase` is POR_WAIT or RESET_HELD. All three are low while `phase` is RUNNING (code 3).
- R5: If `bus_req` is high when reset is released, `phase` stays at RESET_HELD and there is no `boot_start` and no `fetch_req` until `bus_req` drops.
- R6: With `boot_en` high and no bus request, the block gives exactly one single-cycle `boot_start` pulse. `phase` then reads BOOTING (code 2), and there is no `fetch_req` until `boot_done` is seen.
- R7: With `boot_en` low, no `boot_start` is raised, and the fetch follows the release directly.
- R8: Each start-up ends with exactly one single-cycle `fetch_req`, with `fetch_addr` equal to zero. After it, `phase` reads RUNNING and `core_hold` is low.
- R9: While `pwr_ok` is low, `phase` is 0, `core_hold` and the three side-effect strobes are high, and `boot_start` and `fetch_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_ok | input | 1 | Power valid; asynchronous active-low reset of the block |
| rst_ext_n | input | 1 | External reset pin, active low, asynchronous |
| boot_en | input | 1 | Boot strap: run the boot handshake on release |
| bus_req | input | 1 | Bus request pending; delays release while high |
| boot_done | input | 1 | Boot loader reports completion |
| core_hold | output | 1 | Core held in reset (high until RUNNING) |
| sp_clear | output | 1 | Set stack pointers to empty |
| irq_mask_all | output | 1 | Mask every interrupt |
| mstat_clr | output | 1 | Clear mode/status register |
| boot_start | output | 1 | Single-cycle boot request |
| fetch_req | output | 1 | Single-cycle first-fetch request |
| fetch_addr | output | PC_W | Address of the first fetch (zero) |
| phase | output | 2 | 0 POR_WAIT, 1 RESET_HELD, 2 BOOTING, 3 RUNNING |

## Verification
External reset pulses are swept in width from one edge to two edges beyond MIN_PULSE. The sweep shows the exact width at which a dip stops being ignored and becomes a reset. Every combination of boot strap and pending bus request is run through a full reset, which separates the hold, boot and direct-fetch paths. Two cold starts are also run: one with the pin already released and one with the pin held low past the settling window. Together they pin down the window length and show that it is used only once.

// File: rtl/rst_boot_seq.sv
module rst_boot_seq #(
  parameter int LOCK_CYCLES = 2000,
  parameter int MIN_PULSE   = 4,
  parameter int PC_W        = 14
) (
  input  logic            clk,
  input  logic            pwr_ok,
  input  logic            rst_ext_n,
  input  logic            boot_en,
  input  logic            bus_req,
  input  logic            boot_done,
  output logic            core_hold,
  output logic            sp_clear,
  output logic            irq_mask_all,
  output logic            mstat_clr,
  output logic            boot_start,
  output logic            fetch_req,
  output logic [PC_W-1:0] fetch_addr,
  output logic [1:0]      phase
);
  localparam int LCK_W = $clog2(LOCK_CYCLES + 1);
  localparam int PW_W  = $clog2(MIN_PULSE + 1);

  typedef enum logic [2:0] {
    S_POR, S_RST, S_HOLD, S_BSTART, S_BWAIT, S_FETCH, S_RUN
  } state_t;

  state_t           state, nxt;
  logic [1:0]       sync_q;
  logic             rst_s;
  logic [LCK_W-1:0] lock_cnt;
  logic [PW_W-1:0]  low_cnt;
  logic             warm_hit;

  assign rst_s = sync_q[1];

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], rst_ext_n};

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok)            lock_cnt <= '0;
    else if (state == S_POR) lock_cnt <= lock_cnt + 1'b1;

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok)                                        low_cnt <= '0;
    else if (rst_s || state == S_POR || state == S_RST) low_cnt <= '0;
    else if (!warm_hit)                                 low_cnt <= low_cnt + 1'b1;

  assign warm_hit = !rst_s && (low_cnt == PW_W'(MIN_PULSE - 1))
                    && state != S_POR && state != S_RST;

  always_comb begin
    nxt = state;
    case (state)
      S_POR:    if (lock_cnt == LCK_W'(LOCK_CYCLES - 1)) nxt = S_RST;
      S_RST:    if (rst_s) nxt = bus_req ? S_HOLD : (boot_en ? S_BSTART : S_FETCH);
      S_HOLD:   if (!bus_req) nxt = boot_en ? S_BSTART : S_FETCH;
      S_BSTART: nxt = S_BWAIT;
      S_BWAIT:  if (boot_done) nxt = S_FETCH;
      S_FETCH:  nxt = S_RUN;
      default:  nxt = S_RUN;
    endcase
    if (warm_hit) nxt = S_RST;
  end

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok) state <= S_POR;
    else         state <= nxt;

  logic in_rst;
  assign in_rst       = state == S_POR || state == S_RST || state == S_HOLD;
  assign core_hold    = state != S_RUN && state != S_FETCH;
  assign sp_clear     = in_rst;
  assign irq_mask_all = in_rst;
  assign mstat_clr    = in_rst;
  assign boot_start   = state == S_BSTART;
  assign fetch_req    = state == S_FETCH;
  assign fetch_addr   = '0;

  always_comb
    case (state)
      S_POR:                      phase = 2'd0;
      S_RST, S_HOLD:              phase = 2'd1;
      S_BSTART, S_BWAIT:          phase = 2'd2;
      default:                    phase = 2'd3;
    endcase
endmodule

module rst_boot_seq_chk #(parameter int PC_W = 14) (
  input logic            clk,
  input logic            pwr_ok,
  input logic            bus_req,
  input logic            sp_clear,
  input logic            irq_mask_all,
  input logic            mstat_clr,
  input logic            boot_start,
  input logic            fetch_req,
  input logic [PC_W-1:0] fetch_addr,
  input logic [1:0]      phase
);
  AST_NO_POR_REENTRY: assert property (@(posedge clk) disable iff (!pwr_ok)
    phase != 2'd0 |=> phase != 2'd0); // R2
  AST_EFFECTS_OFF_RUN: assert property (@(posedge clk) disable iff (!pwr_ok)
    phase == 2'd3 |-> !sp_clear && !irq_mask_all && !mstat_clr); // R4
  AST_BUSREQ_HOLDS: assert property (@(posedge clk) disable iff (!pwr_ok)
    (phase == 2'd1 && bus_req) |=> !fetch_req && !boot_start); // R5
  AST_BOOT_START_PULSE: assert property (@(posedge clk) disable iff (!pwr_ok)
    boot_start |=> !boot_start && phase == 2'd2); // R6
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!pwr_ok)
    fetch_req |=> !fetch_req); // R8
  AST_FETCH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!pwr_ok)
    fetch_req |-> fetch_addr == '0); // R8
endmodule

bind rst_boot_seq rst_boot_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .pwr_ok(pwr_ok), .bus_req(bus_req), .sp_clear(sp_clear),
  .irq_mask_all(irq_mask_all), .mstat_clr(mstat_clr), .boot_start(boot_start),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .phase(phase));

// File: tb/tb_rst_boot_seq.sv
module tb_rst_boot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 20;
  localparam int MINP = 4;
  localparam int PCW  = 14;

  logic clk = 0, pwr_ok = 0, rst_ext_n = 1, boot_en = 0, bus_req = 0, boot_done = 0;
  logic core_hold, sp_clear, irq_mask_all, mstat_clr, boot_start, fetch_req;
  logic [PCW-1:0] fetch_addr;
  logic [1:0] phase;

  int errors = 0, checks = 0;
  int bs_cnt = 0, fe_cnt = 0, hold_seen = 0, eff_bad = 0, addr_bad = 0, por_back = 0;
  bit left_por = 0, done = 0;

  rst_boot_seq #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MINP), .PC_W(PCW)) dut (
    .clk(clk), .pwr_ok(pwr_ok), .rst_ext_n(rst_ext_n), .boot_en(boot_en),
    .bus_req(bus_req), .boot_done(boot_done), .core_hold(core_hold),
    .sp_clear(sp_clear), .irq_mask_all(irq_mask_all), .mstat_clr(mstat_clr),
    .boot_start(boot_start), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .phase(phase));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (pwr_ok) begin
    if (boot_start) bs_cnt++;
    if (fetch_req) begin fe_cnt++; if (fetch_addr != '0) addr_bad++; end
    if (core_hold) hold_seen++;
    if (phase == 2'd1 && !(sp_clear && irq_mask_all && mstat_clr)) eff_bad++;
    if (phase == 2'd3 && (sp_clear || irq_mask_all || mstat_clr)) eff_bad++;
    if (phase != 2'd0) left_por = 1;
    else if (left_por) por_back++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    bs_cnt = 0; fe_cnt = 0; hold_seen = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); rst_ext_n = 0;
    repeat (n) @(negedge clk);
    rst_ext_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 phase", phase, 0);
    chk("R9 core_hold", core_hold, 1);
    chk("R9 effects", {sp_clear, irq_mask_all, mstat_clr}, 3'b111);
    chk("R9 pulses", {boot_start, fetch_req}, 0);
    // R1 settling window: LOCK edges in POR, negedge samples after release see LOCK-1
    pwr_ok = 1; n = 0;
    forever begin
      @(negedge clk);
      if (phase == 2'd0) n++; else break;
    end
    chk("R1 por length", n, LOCK - 1);
    repeat (6) @(negedge clk);
    chk("R8 first fetch", fe_cnt, 1);
    chk("R8 phase running", phase, 3);
    chk("R8 core_hold low", core_hold, 0);
    chk("R7 no boot at cold start", bs_cnt, 0);

    // R3 pulse width sweep
    for (int w = 1; w <= MINP + 2; w++) begin
      clear_mon();
      pulse(w);
      repeat (12) @(negedge clk);
      chk($sformatf("R3 width %0d hold", w), hold_seen > 0, w >= MINP);
      chk($sformatf("R3 width %0d fetch", w), fe_cnt, (w >= MINP) ? 1 : 0);
      chk($sformatf("R3 width %0d phase", w), phase, 3);
    end

    // boot strap x bus request combinations
    for (int be = 0; be < 2; be++)
      for (int br = 0; br < 2; br++) begin
        boot_en = be[0]; bus_req = br[0];
        clear_mon();
        pulse(MINP + 2);
        repeat (8) @(negedge clk);
        if (br) begin
          chk("R5 held phase", phase, 1);
          chk("R5 no fetch", fe_cnt, 0);
          chk("R5 no boot_start", bs_cnt, 0);
          bus_req = 0;
          repeat (4) @(negedge clk);
        end
        if (be) begin
          chk("R6 one boot_start", bs_cnt, 1);
          chk("R6 booting phase", phase, 2);
          chk("R6 no fetch before done", fe_cnt, 0);
          boot_done = 1; @(negedge clk); boot_done = 0;
          repeat (4) @(negedge clk);
        end else
          chk("R7 no boot_start", bs_cnt, 0);
        chk("R8 one fetch", fe_cnt, 1);
        chk("R8 running", phase, 3);
      end
    boot_en = 0;

    // R2 cold start with pin held low past settling
    @(negedge clk); pwr_ok = 0; rst_ext_n = 0; left_por = 0;
    @(negedge clk);
    chk("R9 second reset phase", phase, 0);
    pwr_ok = 1; clear_mon();
    repeat (LOCK + 6) @(negedge clk);
    chk("R2 held after window", phase, 1);
    chk("R2 no fetch while pin low", fe_cnt, 0);
    rst_ext_n = 1;
    repeat (6) @(negedge clk);
    chk("R2 fetch after pin release", fe_cnt, 1);
    chk("R2 no return to POR", por_back, 0);
    chk("R4 effects follow phase", eff_bad, 0);
    chk("R8 address zero", addr_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule